// File: doc/BRIEF.md
# Two-Bank Peripheral Interrupt Router

This block collects level-sensitive interrupt requests from on-chip peripherals, split over two banks of 32 lines each. Each line has an enable bit and a routing bit. An enabled line whose routing bit is clear drives the normal interrupt output. An enabled line whose routing bit is set drives the fast interrupt output. Both outputs are registered ORs of their pending vectors. The block never latches a request. A pending bit follows its input line, and software quietens a line by clearing its enable bit.

A small synchronous register port gives software access. It has a word address, a write strobe, 32-bit write data and 32-bit read data that appears one clock after the address. Each bank has two writable registers, enable and routing. Each bank also has three read-only views: pending-normal, pending-fast and the raw line state. One shared control register holds a wake-policy bit. When that bit is set, only enabled active lines raise the idle-wake output. When it is clear, any active line raises the idle-wake output, whether enabled or not.

The block has no state machine. Its only sequential elements are the configuration registers, the three output flops and the read-data register.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, every enable bit, routing bit and the wake-policy bit read 0, and `irq_o`, `fiq_o` and `wake_o` are 0 even with all lines active.
- R2: A write to word address bank*8+2 loads that bank's enable register, and the value reads back one clock after the read address. Enable bit 1 means enabled. No other access changes the register.
- R3: A write to word address bank*8+3 loads that bank's routing register, and the value reads back the same way. Routing bit 0 selects the normal output and 1 selects the fast output. No other access changes the register.
- R4: `irq_o` equals the OR over all lines of (line AND enable AND NOT routing), as those values stood one clock earlier.
- R5: `fiq_o` equals the OR over all lines of (line AND enable AND routing), as those values stood one clock earlier.
- R6: Reading word address bank*8+0 returns that bank's line AND enable AND NOT routing.
- R7: Reading word address bank*8+1 returns that bank's line AND enable AND routing.
- R8: Reading word address bank*8+4 returns that bank's raw line state, whatever the enable bits hold.
- R9: With wake-policy bit 1, `wake_o` equals, one clock later, the OR over all lines of (line AND enable).
- R10: With wake-policy bit 0, `wake_o` equals, one clock later, the OR of all lines, enabled or not.
- R11: The wake-policy bit is bit 0 of word address 16 (bank count times 8), and the other bits of that register read 0. Writes to read-only or unmapped addresses change nothing, and reads of unmapped addresses return 0.
- R12: Line n of `src_i` belongs to bank n/32 at bit n mod 32, and the lines are level-sensitive. A line that drops clears its pending bit and its output contribution with no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level interrupt lines, bank-major |
| addr_i | input | 5 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one clock after address |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |
| wake_o | output | 1 | Idle-wake request |

## Verification
Every result of this block is due exactly one clock after its cause. The three outputs follow a line, enable or routing change by one edge. Read data follows the address by one edge. A register written on an edge is visible to the output logic from that edge on. The bench therefore drives every input on a falling edge and samples one full period later, on the next falling edge. For output checks that follow a register write, it waits one further period after the write completes. Sweeps walk a single active line through all 64 positions under several enable and routing patterns, and the expected values come from a bit-level model kept in the bench.

// File: rtl/irq_fiq_pkg.sv
package irq_fiq_pkg;

    localparam int DATA_W     = 32;
    localparam int REG_STRIDE = 8;
    localparam int OFFS_W     = 3;

    // word offset inside one bank's window
    typedef enum logic [OFFS_W-1:0] {
        REG_PEND_NRM  = 3'd0,
        REG_PEND_FAST = 3'd1,
        REG_ENABLE    = 3'd2,
        REG_ROUTE     = 3'd3,
        REG_RAW       = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/irq_fiq_bank.sv
module irq_fiq_bank
    import irq_fiq_pkg::*;
#(
    parameter int BW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [BW-1:0] src_i,
    input  logic          wr_en_i,
    input  logic          wr_route_i,
    input  logic [BW-1:0] wdata_i,
    output logic [BW-1:0] enable_o,
    output logic [BW-1:0] route_o,
    output logic [BW-1:0] pend_nrm_o,
    output logic [BW-1:0] pend_fast_o
);

    logic [BW-1:0] enable_q;
    logic [BW-1:0] route_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            enable_q <= '0;
            route_q  <= '0;
        end else begin
            if (wr_en_i) begin
                enable_q <= wdata_i;
            end
            if (wr_route_i) begin
                route_q <= wdata_i;
            end
        end
    end

    assign enable_o    = enable_q;
    assign route_o     = route_q;
    assign pend_nrm_o  = src_i & enable_q & ~route_q;
    assign pend_fast_o = src_i & enable_q &  route_q;

    // R2
    enable_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(enable_q));
    // R2
    enable_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> enable_q == $past(wdata_i));
    // R3
    route_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_route_i |=> $stable(route_q));
    // R3
    route_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_route_i |=> route_q == $past(wdata_i));

endmodule

// File: rtl/irq_fiq_rdmux.sv
module irq_fiq_rdmux
    import irq_fiq_pkg::*;
#(
    parameter int NB = 2,
    parameter int BW = 32,
    parameter int AW = 5
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [AW-1:0]          addr_i,
    input  logic [NB-1:0][BW-1:0]  pend_nrm_i,
    input  logic [NB-1:0][BW-1:0]  pend_fast_i,
    input  logic [NB-1:0][BW-1:0]  enable_i,
    input  logic [NB-1:0][BW-1:0]  route_i,
    input  logic [NB-1:0][BW-1:0]  raw_i,
    input  logic                   ctrl_i,
    output logic [DATA_W-1:0]      rdata_o
);

    localparam int CTRL_ADDR = NB * REG_STRIDE;
    localparam int BSEL_W    = AW - OFFS_W;

    logic [BSEL_W-1:0] bsel;
    reg_sel_e          offs;
    logic [DATA_W-1:0] rd_next;
    logic              hit;
    logic [DATA_W-1:0] rdata_q;

    assign bsel = addr_i[AW-1:OFFS_W];
    assign offs = reg_sel_e'(addr_i[OFFS_W-1:0]);

    always_comb begin
        rd_next = '0;
        hit     = 1'b0;
        if (addr_i == AW'(CTRL_ADDR)) begin
            rd_next = DATA_W'(ctrl_i);
            hit     = 1'b1;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (bsel == BSEL_W'(b)) begin
                    case (offs)
                        REG_PEND_NRM:  begin rd_next = DATA_W'(pend_nrm_i[b]);  hit = 1'b1; end
                        REG_PEND_FAST: begin rd_next = DATA_W'(pend_fast_i[b]); hit = 1'b1; end
                        REG_ENABLE:    begin rd_next = DATA_W'(enable_i[b]);    hit = 1'b1; end
                        REG_ROUTE:     begin rd_next = DATA_W'(route_i[b]);     hit = 1'b1; end
                        REG_RAW:       begin rd_next = DATA_W'(raw_i[b]);       hit = 1'b1; end
                        default:       begin rd_next = '0; end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_next;
        end
    end

    assign rdata_o = rdata_q;

    // R11
    unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit |=> rdata_o == '0);

endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
    import irq_fiq_pkg::*;
#(
    parameter  int NUM_BANKS = 2,
    parameter  int BANK_W    = 32,
    localparam int SRC_W     = NUM_BANKS * BANK_W,
    localparam int ADDR_W    = $clog2(NUM_BANKS * REG_STRIDE + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              wake_o
);

    localparam int CTRL_ADDR = NUM_BANKS * REG_STRIDE;
    localparam int BSEL_W    = ADDR_W - OFFS_W;

    logic [NUM_BANKS-1:0][BANK_W-1:0] src_b;
    logic [NUM_BANKS-1:0][BANK_W-1:0] enable_all;
    logic [NUM_BANKS-1:0][BANK_W-1:0] route_all;
    logic [NUM_BANKS-1:0][BANK_W-1:0] pend_nrm_all;
    logic [NUM_BANKS-1:0][BANK_W-1:0] pend_fast_all;
    logic [NUM_BANKS-1:0]             wr_en;
    logic [NUM_BANKS-1:0]             wr_route;
    logic                             ctrl_q;
    logic                             irq_q;
    logic                             fiq_q;
    logic                             wake_q;

    assign src_b = src_i;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign wr_en[b]    = we_i && (addr_i[ADDR_W-1:OFFS_W] == BSEL_W'(b))
                                  && (addr_i[OFFS_W-1:0] == REG_ENABLE);
        assign wr_route[b] = we_i && (addr_i[ADDR_W-1:OFFS_W] == BSEL_W'(b))
                                  && (addr_i[OFFS_W-1:0] == REG_ROUTE);

        irq_fiq_bank #(
            .BW (BANK_W)
        ) bank_i (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .src_i       (src_b[b]),
            .wr_en_i     (wr_en[b]),
            .wr_route_i  (wr_route[b]),
            .wdata_i     (wdata_i[BANK_W-1:0]),
            .enable_o    (enable_all[b]),
            .route_o     (route_all[b]),
            .pend_nrm_o  (pend_nrm_all[b]),
            .pend_fast_o (pend_fast_all[b])
        );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= 1'b0;
        end else if (we_i && addr_i == ADDR_W'(CTRL_ADDR)) begin
            ctrl_q <= wdata_i[0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q  <= 1'b0;
            fiq_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            irq_q  <= |pend_nrm_all;
            fiq_q  <= |pend_fast_all;
            wake_q <= ctrl_q ? |(src_b & enable_all) : |src_b;
        end
    end

    assign irq_o  = irq_q;
    assign fiq_o  = fiq_q;
    assign wake_o = wake_q;

    irq_fiq_rdmux #(
        .NB (NUM_BANKS),
        .BW (BANK_W),
        .AW (ADDR_W)
    ) rdmux_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .addr_i      (addr_i),
        .pend_nrm_i  (pend_nrm_all),
        .pend_fast_i (pend_fast_all),
        .enable_i    (enable_all),
        .route_i     (route_all),
        .raw_i       (src_b),
        .ctrl_i      (ctrl_q),
        .rdata_o     (rdata_o)
    );

    // R4
    irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(|(src_b & enable_all & ~route_all)));
    // R5
    fiq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fiq_o |-> $past(|(src_b & enable_all & route_all)));
    // R9
    wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_o && $past(ctrl_q)) |-> $past(|(src_b & enable_all)));
    // R10
    wake_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(!ctrl_q) && $past(|src_b)) |-> wake_o);

endmodule

// File: tb/irq_fiq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_fiq_ctrl_tb_top;

    logic        clk;
    logic        rst_n;
    logic [63:0] src;
    logic [4:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq, fiq, wake;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [63:0] m_en, m_rt;
    logic        m_ctrl;

    irq_fiq_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .we_i(we),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
    );

    initial clk = 0;
    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 5'(a); we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 5'(a);
        @(negedge clk);
        d = rdata;
    endtask

    task automatic set_en(input int b, input logic [31:0] d);
        wr(b*8+2, d); m_en[b*32 +: 32] = d;
    endtask

    task automatic set_rt(input int b, input logic [31:0] d);
        wr(b*8+3, d); m_rt[b*32 +: 32] = d;
    endtask

    function automatic logic e_irq();  return |(src & m_en & ~m_rt); endfunction
    function automatic logic e_fiq();  return |(src & m_en & m_rt);  endfunction
    function automatic logic e_wake(); return m_ctrl ? |(src & m_en) : |src; endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 0; we = 0; addr = '0; wdata = '0; src = '1;
        m_en = '0; m_rt = '0; m_ctrl = 0;
        repeat (3) @(negedge clk);
        // R1 outputs quiet under reset with all lines active
        chk("R1", "irq in reset", 32'(irq), 0);
        chk("R1", "fiq in reset", 32'(fiq), 0);
        chk("R1", "wake in reset", 32'(wake), 0);
        src = '0;
        @(negedge clk);
        rst_n = 1;
        rd(2, v);  chk("R1", "enable0", v, 0);
        rd(10, v); chk("R1", "enable1", v, 0);
        rd(3, v);  chk("R1", "route0", v, 0);
        rd(11, v); chk("R1", "route1", v, 0);
        rd(16, v); chk("R1", "ctrl", v, 0);
        chk("R1", "irq after reset", 32'(irq), 0);
        chk("R1", "wake after reset", 32'(wake), 0);

        // R2 / R3 write and read back
        set_en(0, 32'hDEADBEEF); set_en(1, 32'h12345678);
        set_rt(0, 32'hCAFEF00D); set_rt(1, 32'h87654321);
        rd(2, v);  chk("R2", "enable0", v, 32'hDEADBEEF);
        rd(10, v); chk("R2", "enable1", v, 32'h12345678);
        rd(3, v);  chk("R3", "route0", v, 32'hCAFEF00D);
        rd(11, v); chk("R3", "route1", v, 32'h87654321);

        // R11 control field, read-only and unmapped addresses
        wr(16, 32'hFFFFFFFE); rd(16, v); chk("R11", "ctrl bit0 clear", v, 0);
        wr(16, 32'hFFFFFFFF); rd(16, v); chk("R11", "ctrl bit0 set", v, 1);
        wr(16, 0);
        wr(0, 32'hFFFFFFFF); wr(1, 32'hFFFFFFFF); wr(4, 32'h0);
        wr(20, 32'h0); wr(5, 32'h0); wr(12, 32'h0);
        rd(2, v);  chk("R11", "enable0 after RO writes", v, 32'hDEADBEEF);
        rd(3, v);  chk("R11", "route0 after RO writes", v, 32'hCAFEF00D);
        rd(10, v); chk("R11", "enable1 after unmapped writes", v, 32'h12345678);
        rd(16, v); chk("R11", "ctrl after writes", v, 0);
        foreach (v[i]) begin end
        for (int a = 17; a < 32; a++) begin
            rd(a, v); chk("R11", $sformatf("unmapped %0d", a), v, 0);
        end
        rd(5, v);  chk("R11", "unmapped 5", v, 0);
        rd(15, v); chk("R11", "unmapped 15", v, 0);

        // Sweep: all enabled, mixed routing
        set_en(0, '1); set_en(1, '1);
        set_rt(0, 32'hA5A53C3C); set_rt(1, 32'h0F0FF0F0);
        for (int n = 0; n < 64; n++) begin
            int b;
            b = n / 32;
            @(negedge clk); src = 64'(1) << n;
            @(negedge clk);
            chk("R4", $sformatf("irq line %0d", n), 32'(irq), 32'(e_irq()));
            chk("R5", $sformatf("fiq line %0d", n), 32'(fiq), 32'(e_fiq()));
            rd(b*8+0, v);
            chk("R6", $sformatf("pend nrm line %0d", n), v, (src & m_en & ~m_rt) >> (b*32));
            rd(b*8+1, v);
            chk("R7", $sformatf("pend fast line %0d", n), v, (src & m_en & m_rt) >> (b*32));
            rd((1-b)*8+4, v);
            chk("R12", $sformatf("other bank raw line %0d", n), v, 0);
        end
        // R12 level-sensitive drop
        @(negedge clk); src = '0;
        @(negedge clk);
        chk("R12", "irq drops", 32'(irq), 0);
        chk("R12", "fiq drops", 32'(fiq), 0);

        // Partial enables, wake policy 1
        set_en(0, 32'h0000FFFF); set_en(1, 32'hFFFF0000);
        wr(16, 1); m_ctrl = 1;
        for (int n = 0; n < 64; n++) begin
            @(negedge clk); src = 64'(1) << n;
            @(negedge clk);
            chk("R4", $sformatf("masked irq %0d", n), 32'(irq), 32'(e_irq()));
            chk("R5", $sformatf("masked fiq %0d", n), 32'(fiq), 32'(e_fiq()));
            chk("R9", $sformatf("wake gated %0d", n), 32'(wake), 32'(e_wake()));
            rd((n/32)*8+4, v);
            chk("R8", $sformatf("raw %0d", n), v, 32'(1) << (n % 32));
        end

        // Wake policy 0
        wr(16, 0); m_ctrl = 0;
        for (int n = 0; n < 64; n++) begin
            @(negedge clk); src = 64'(1) << n;
            @(negedge clk);
            chk("R10", $sformatf("wake any %0d", n), 32'(wake), 1);
            chk("R4", $sformatf("irq pol0 %0d", n), 32'(irq), 32'(e_irq()));
        end
        @(negedge clk); src = '0;
        @(negedge clk);
        chk("R10", "wake idle", 32'(wake), 0);

        // Multi-line patterns
        set_en(0, 32'hF00F_1234); set_en(1, 32'h0FF0_8001);
        for (int p = 0; p < 6; p++) begin
            @(negedge clk);
            src = {32'h9E3779B9 * (p+1), 32'h7F4A7C15 ^ (p * 32'h01010101)};
            @(negedge clk);
            chk("R4", $sformatf("pattern irq %0d", p), 32'(irq), 32'(e_irq()));
            chk("R5", $sformatf("pattern fiq %0d", p), 32'(fiq), 32'(e_fiq()));
            chk("R10", $sformatf("pattern wake %0d", p), 32'(wake), 32'(e_wake()));
            rd(8, v);
            chk("R6", $sformatf("pattern pend nrm1 %0d", p), v, (src & m_en & ~m_rt) >> 32);
            rd(1, v);
            chk("R7", $sformatf("pattern pend fast0 %0d", p), v, 32'(src & m_en & m_rt));
        end

        done = 1;
        finish_run();
    end

endmodule